// File: doc/BRIEF.md
# Single-Port SRAM with Grouped Write Enables

This block is a synthesizable behavioural model of a synchronous single-port memory. Address, data, chip select and the write-enable bus are captured on the rising clock edge. The write-enable bus also selects the operation. When any of its bits is high the cycle is a write, and each high bit stores one slice of the data input. When every bit is low the cycle is a read, and the addressed word is loaded into an output register.

A group-size parameter sets how many data bits each enable bit governs. A value of zero gives a single enable that covers the whole word. The output register drives the data output through a three-state buffer controlled by an output-enable pin. Parameter limits are checked at elaboration, and an illegal combination stops the build.

Top module: `grouped_wr_sram`

## Requirements
- R1: While `cen_n` is high at a rising edge, no access takes place. Memory contents do not change and the output register keeps its value, whatever `wen`, `addr` and `din` carry.
- R2: With `cen_n` low and all `wen` bits low at a rising edge, the word at `addr` is loaded into the output register. It is visible on `dout` after that edge. A word written in one cycle is returned by a read of the same address in the next cycle.
- R3: With `cen_n` low, each high bit j of `wen` stores `din[j*G+G-1 : j*G]` into the addressed word, where G is the group size (4 by default, so bit 0 covers bits 3:0 and bit 3 covers bits 15:12). Groups whose bit is low keep their old content.
- R4: A cycle in which some `wen` bits are high and others are low is a write of the enabled groups only. No read takes place, and the output register holds its value.
- R5: With `GROUP_BITS` = 0, `wen` is one bit wide, and that bit writes the entire word.
- R6: `dout` is driven only while `oe` is high and is high impedance otherwise. `oe` acts without waiting for a clock edge. It changes neither the memory nor the output register, so a read made while `oe` is low shows once `oe` rises.
- R7: The output register holds its last read value through write cycles, idle cycles and periods with `oe` low.
- R8: Elaboration fails unless all of the following hold: the data width is at least 2; the depth is at least 2; the data width is an exact multiple of the group size; the column factor is 4, 8 or 16; the width is at most 1024 divided by the column factor; the depth is at most 512 times the column factor. The enable bus is `WIDTH/GROUP_BITS` bits wide, or 1 bit wide when `GROUP_BITS` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything except `oe` is sampled on its rising edge |
| cen_n | input | 1 | Chip select, active low |
| wen | input | NGRP | Per-group write enables; all low means read |
| addr | input | AW | Word address |
| din | input | WIDTH | Write data |
| oe | input | 1 | Output enable, active high |
| dout | output | WIDTH | Registered read data, high impedance while `oe` is low |

## Verification
The hardest case to reach from the ports is a partial write whose result must be told apart from a full write. If the old content of the untouched groups equalled the new data, a design that wrote every group would look correct. The stimulus therefore fills every word with an address-dependent pattern first. It then applies every mixed enable value with data that is the complement of that pattern, and reads each word back against a reference array. The same sequence runs with `oe` held high, so that each write and idle cycle also shows whether the output register held its value.

// File: rtl/grouped_wr_sram_pkg.sv
package grouped_wr_sram_pkg;

    // widest word allowed for a given column factor
    function automatic int max_width(input int colf);
        return 1024 / colf;
    endfunction

    // deepest array allowed for a given column factor
    function automatic int max_words(input int colf);
        return 512 * colf;
    endfunction

    // bits governed by one enable bit; zero means the whole word
    function automatic int group_size(input int width, input int gbits);
        return (gbits == 0) ? width : gbits;
    endfunction

    function automatic int group_count(input int width, input int gbits);
        int gs;
        gs = group_size(width, gbits);
        return (gs > 0) ? (width / gs) : 1;
    endfunction

    function automatic bit colf_legal(input int colf);
        return (colf == 4) || (colf == 8) || (colf == 16);
    endfunction

endpackage

// File: rtl/sram_wen_expand.sv
module sram_wen_expand #(
    parameter int WIDTH = 16,
    parameter int GSIZE = 4,
    parameter int NGRP  = 4
) (
    input  logic             access,
    input  logic [NGRP-1:0]  wen,
    output logic [WIDTH-1:0] bit_wr,
    output logic             rd_en
);

    // one enable bit fans out to its slice of the data word
    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        assign bit_wr[g*GSIZE +: GSIZE] = {GSIZE{access & wen[g]}};
    end

    // read only when the chip is selected and no group asks to write
    assign rd_en = access & ~(|wen);

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int WORDS = 64,
    parameter int WIDTH = 16,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] bit_wr,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_word
);

    typedef struct packed {
        logic [WIDTH-1:0] rdata;
        logic             primed;
    } st_t;

    logic [WIDTH-1:0] mem [WORDS];
    st_t              st_d;
    st_t              st_q = '0;
    logic [WIDTH-1:0] row_d;
    logic             wr_d;
    logic             in_range;

    assign in_range = ({1'b0, addr} < (AW+1)'(WORDS));

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        row_d       = '0;
        wr_d        = 1'b0;
        if (in_range) begin
            row_d = (mem[addr] & ~bit_wr) | (din & bit_wr);
            wr_d  = |bit_wr;
            if (rd_en) begin
                st_d.rdata = mem[addr];
            end
        end else if (rd_en) begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (wr_d) begin
            mem[addr] <= row_d;
        end
    end

    assign rd_word = st_q.rdata;

    AST_ENABLED_GROUPS_STORED: assert property (@(posedge clk) disable iff (!st_q.primed)
        (|bit_wr && in_range) |=> ((mem[$past(addr)] & $past(bit_wr)) === ($past(din) & $past(bit_wr)))); // R3

    AST_MASKED_GROUPS_KEPT: assert property (@(posedge clk) disable iff (!st_q.primed)
        (|bit_wr && in_range) |=> ((mem[$past(addr)] & ~$past(bit_wr)) === $past(mem[addr] & ~bit_wr))); // R3

    AST_READ_EXCLUDES_WRITE: assert property (@(posedge clk) disable iff (!st_q.primed)
        rd_en |-> (bit_wr == '0)); // R4

endmodule

// File: rtl/grouped_wr_sram.sv
module grouped_wr_sram
    import grouped_wr_sram_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int WIDTH      = 16,
    parameter int GROUP_BITS = 4,
    parameter int COLF       = 16,
    localparam int GSIZE     = group_size(WIDTH, GROUP_BITS),
    localparam int NGRP      = group_count(WIDTH, GROUP_BITS),
    localparam int AW        = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             cen_n,
    input  logic [NGRP-1:0]  wen,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic             oe,
    output logic [WIDTH-1:0] dout
);

    // R8: parameter legality, checked at elaboration
    if (WIDTH < 2) begin : g_bad_width
        $error("grouped_wr_sram: WIDTH must be at least 2");
    end
    if (WORDS < 2) begin : g_bad_words
        $error("grouped_wr_sram: WORDS must be at least 2");
    end
    if (GSIZE < 1 || (WIDTH % GSIZE) != 0) begin : g_bad_group
        $error("grouped_wr_sram: WIDTH must be a multiple of GROUP_BITS");
    end
    if (!colf_legal(COLF)) begin : g_bad_colf
        $error("grouped_wr_sram: COLF must be 4, 8 or 16");
    end
    if (WIDTH > max_width(COLF)) begin : g_wide
        $error("grouped_wr_sram: WIDTH too large for COLF");
    end
    if (WORDS > max_words(COLF)) begin : g_deep
        $error("grouped_wr_sram: WORDS too large for COLF");
    end

    logic [WIDTH-1:0] bit_wr;
    logic             rd_en;
    logic [WIDTH-1:0] rd_word;
    logic             armed_d;
    logic             armed_q = 1'b0;

    sram_wen_expand #(
        .WIDTH (WIDTH),
        .GSIZE (GSIZE),
        .NGRP  (NGRP)
    ) u_wen_expand (
        .access (~cen_n),
        .wen    (wen),
        .bit_wr (bit_wr),
        .rd_en  (rd_en)
    );

    sram_store #(
        .WORDS (WORDS),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_store (
        .clk     (clk),
        .addr    (addr),
        .din     (din),
        .bit_wr  (bit_wr),
        .rd_en   (rd_en),
        .rd_word (rd_word)
    );

    always_comb begin
        armed_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        armed_q <= armed_d;
    end

    // R6: three-state output stage
    assign dout = oe ? rd_word : {WIDTH{1'bz}};

    AST_DESELECT_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!armed_q)
        cen_n |=> $stable(rd_word)); // R1

    AST_WRITE_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!armed_q)
        (!cen_n && (|wen)) |=> $stable(rd_word)); // R7

endmodule

// File: tb/grouped_wr_sram_bench.sv
`timescale 1ns/1ps
module grouped_wr_sram_bench;

    localparam int WORDS = 64;
    localparam int WIDTH = 16;
    localparam int NG    = 4;
    localparam int AW    = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             cen_n = 1'b1;
    logic             oe    = 1'b0;
    logic [NG-1:0]    wen   = '0;
    logic [AW-1:0]    addr  = '0;
    logic [WIDTH-1:0] din   = '0;
    wire  [WIDTH-1:0] dout;

    logic             cen2_n = 1'b1;
    logic             oe2    = 1'b0;
    logic [0:0]       wen2   = '0;
    logic [AW-1:0]    addr2  = '0;
    logic [WIDTH-1:0] din2   = '0;
    wire  [WIDTH-1:0] dout2;

    grouped_wr_sram #(.WORDS(WORDS), .WIDTH(WIDTH), .GROUP_BITS(4), .COLF(16)) u_grouped_wr_sram (
        .clk(clk), .cen_n(cen_n), .wen(wen), .addr(addr), .din(din), .oe(oe), .dout(dout));

    grouped_wr_sram #(.WORDS(WORDS), .WIDTH(WIDTH), .GROUP_BITS(0), .COLF(16)) u_grouped_wr_sram_whole (
        .clk(clk), .cen_n(cen2_n), .wen(wen2), .addr(addr2), .din(din2), .oe(oe2), .dout(dout2));

    typedef struct {
        int               stamp;
        logic [WIDTH-1:0] exp;
        bit               hiz;
        bit               which;
        string            req;
    } exp_t;

    exp_t             sb[$];
    logic [WIDTH-1:0] ref_mem  [WORDS];
    logic [WIDTH-1:0] ref2_mem [WORDS];
    logic [WIDTH-1:0] model_q, model2_q;
    bit               model_ok = 0, model2_ok = 0;
    int               cyc = 0;
    int               vectors = 0;
    int               errs = 0;
    bit               done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [WIDTH-1:0] pat(input int a);
        return 16'hA5C3 ^ 16'(a * 16'h0101) ^ 16'(a << 3);
    endfunction

    // driver: applies one cycle of stimulus and pushes the expected output
    task automatic step(input logic c, input logic [NG-1:0] w, input int a,
                        input logic [WIDTH-1:0] d, input logic o, input string req);
        @(negedge clk); #1;
        cen_n = c; wen = w; addr = a[AW-1:0]; din = d; oe = o;
        if (!c) begin
            if (w == '0) begin
                model_q  = ref_mem[a];
                model_ok = 1;
            end else begin
                for (int g = 0; g < NG; g++)
                    if (w[g]) ref_mem[a][g*4 +: 4] = d[g*4 +: 4];
            end
        end
        if (!o)            sb.push_back('{cyc + 1, 'x, 1'b1, 1'b0, req});
        else if (model_ok) sb.push_back('{cyc + 1, model_q, 1'b0, 1'b0, req});
    endtask

    task automatic step2(input logic c, input logic w, input int a,
                         input logic [WIDTH-1:0] d, input string req);
        @(negedge clk); #1;
        cen2_n = c; wen2 = w; addr2 = a[AW-1:0]; din2 = d; oe2 = 1'b1;
        cen_n = 1'b1;
        if (!c) begin
            if (!w) begin
                model2_q  = ref2_mem[a];
                model2_ok = 1;
            end else begin
                ref2_mem[a] = d;
            end
        end
        if (model2_ok) sb.push_back('{cyc + 1, model2_q, 1'b0, 1'b1, req});
    endtask

    // monitor: pops matured expectations and compares them with the pins
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].stamp == cyc) begin
            exp_t e;
            logic [WIDTH-1:0] act;
            e   = sb.pop_front();
            act = e.which ? dout2 : dout;
            vectors++;
            if (e.hiz) begin
                if (act !== {WIDTH{1'bz}}) begin
                    errs++;
                    $display("FAIL %s: dout=%h expected=zzzz at cycle %0d", e.req, act, cyc);
                end
            end else if (act !== e.exp) begin
                errs++;
                $display("FAIL %s: dout=%h expected=%h at cycle %0d", e.req, act, e.exp, cyc);
            end
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run not finished, actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R8: derived enable bus widths
        vectors++;
        if ($bits(wen) != 4 || $bits(wen2) != 1) begin
            errs++;
            $display("FAIL R8: enable widths %0d/%0d expected 4/1", $bits(wen), $bits(wen2));
        end

        // start-up: deselected, output disabled (R6)
        for (int i = 0; i < 4; i++) step(1'b1, '0, 0, '0, 1'b0, "R6");

        // fill every word with a full-group write (R3)
        for (int a = 0; a < WORDS; a++) step(1'b0, 4'hF, a, pat(a), 1'b0, "R3");

        // read every word back (R2)
        for (int a = 0; a < WORDS; a++) step(1'b0, '0, a, 16'hFFFF, 1'b1, "R2");

        // every mixed enable value with complement data; output must hold (R4, R7)
        for (int w = 1; w < 15; w++) step(1'b0, 4'(w), w, ~pat(w), 1'b1, "R4");
        for (int w = 1; w < 15; w++) step(1'b0, '0, w, '0, 1'b1, "R3");

        // deselected cycles change nothing (R1)
        step(1'b0, '0, 40, '0, 1'b1, "R2");
        step(1'b1, 4'hF, 40, 16'hBEEF, 1'b1, "R1");
        step(1'b1, 4'h0, 41, 16'h1234, 1'b1, "R1");
        step(1'b1, 4'h0, 41, 16'h1234, 1'b1, "R1");
        step(1'b0, '0, 40, '0, 1'b1, "R1");

        // write then read the same address in the next cycle (R2)
        step(1'b0, 4'hF, 50, 16'h7E81, 1'b1, "R7");
        step(1'b0, '0, 50, '0, 1'b1, "R2");
        step(1'b0, 4'b1001, 50, 16'h0FF0, 1'b1, "R7");
        step(1'b0, '0, 50, '0, 1'b1, "R2");

        // output enable toggling, read made while disabled (R6, R7)
        step(1'b0, '0, 10, '0, 1'b0, "R6");
        step(1'b1, '0, 0, '0, 1'b1, "R6");
        step(1'b1, '0, 0, '0, 1'b0, "R6");
        step(1'b0, 4'h3, 10, 16'h5555, 1'b0, "R6");
        step(1'b1, '0, 0, '0, 1'b1, "R7");
        step(1'b0, '0, 10, '0, 1'b1, "R3");

        // whole-word mode (R5)
        step2(1'b0, 1'b1, 3, 16'hC3A5, "R5");
        step2(1'b0, 1'b0, 3, '0, "R5");
        step2(1'b0, 1'b1, 3, 16'h0F0F, "R5");
        step2(1'b0, 1'b0, 3, '0, "R5");
        step2(1'b1, 1'b1, 3, 16'hFFFF, "R1");
        step2(1'b0, 1'b0, 3, '0, "R1");
        step2(1'b1, 1'b0, 3, '0, "R1");

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule